// File: doc/BRIEF.md
# Multi-Thread Busy-Aware Request Scheduler

This block sits on the master side of a threaded point-to-point request/response link. Each of `NTHR` local threads has its own request queue. Each cycle the scheduler picks at most one queued request and presents it on the shared request lanes, with its thread number on `m_thread_id`. The slave drives one busy bit per thread. The scheduler never presents a request for a thread whose bit is set, so the slave has no need to stall a command, and in this design it cannot.

Responses come back tagged with the slave's thread number. The scheduler steers each response into that thread's response buffer, where the local consumer drains it. In the other direction the scheduler raises a per-thread busy bit toward the slave when a thread's buffer is close to full. The margin it leaves covers one response that may already be on its way.

Order is kept inside each thread. Across threads there is no ordering, and a round-robin pointer shares the link fairly among the threads that are able to go.

Top module: `thread_req_sched`

## Requirements
- R1: After reset, `m_cmd` is idle (2'b00), every `rq_ready` bit is 1, every `m_thread_busy` bit is 0 and every `rs_valid` bit is 0.
- R2: A request is never presented for thread t in a cycle where `s_thread_busy[t]` is 1. Bit t of that vector belongs to thread t.
- R3: Requests of a single thread leave on the link in the order that thread's queue accepted them.
- R4: At most one request is presented per cycle. Among the eligible threads, the first one found scanning upward (with wrap) from the round-robin pointer wins. After a grant to thread t the pointer moves to t+1 modulo `NTHR`. The pointer is 0 after reset.
- R5: A presented request drives `m_cmd` = 2'b01 for a write and 2'b10 for a read. It also drives the queued address on `m_addr` and the thread index on `m_thread_id`. A write carries its queued data on `m_data`, while a read drives zero there. The request lanes are combinational from the queue heads and `s_thread_busy`, so the request appears in the same cycle the thread becomes eligible.
- R6: Each request queue holds `REQ_DEPTH` entries. `rq_ready[t]` is 0 while queue t is full, and a request offered while it is full is not stored.
- R7: A response with `s_resp` = 2'b01 is written into the buffer selected by `s_thread_id`. Each thread's buffer hands its responses out on `rs_valid`/`rs_data` in arrival order, and one is popped on `rs_valid & rs_ready`.
- R8: `m_thread_busy[t]` is 1 exactly when thread t's response buffer has one free entry or none. The buffer still accepts one more response once the bit is set. The bit clears in the cycle after a pop brings the free count back to two.
- R9: A thread is eligible when its queue is non-empty and its slave busy bit is clear. When no thread is eligible, `m_cmd` is idle. When at least one is eligible, a request is presented.
- R10: A cycle with `s_resp` = 2'b00 stores nothing in any buffer, whatever `s_thread_id` and `s_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_valid | input | NTHR | Per-thread request offer |
| rq_ready | output | NTHR | Per-thread queue has room |
| rq_write | input | NTHR | Per-thread request kind: 1 write, 0 read |
| rq_addr | input | NTHR*ADDR_W | Per-thread address, thread t at slice t |
| rq_wdata | input | NTHR*DATA_W | Per-thread write data, thread t at slice t |
| m_cmd | output | 2 | Link command: 00 idle, 01 write, 10 read |
| m_addr | output | ADDR_W | Link address |
| m_data | output | DATA_W | Link write data |
| m_thread_id | output | TID_W | Thread of the presented request |
| s_thread_busy | input | NTHR | Slave per-thread request busy |
| s_resp | input | 2 | Slave response: 00 none, 01 data valid |
| s_data | input | DATA_W | Slave response data |
| s_thread_id | input | TID_W | Thread of the response |
| m_thread_busy | output | NTHR | Master per-thread response busy |
| rs_valid | output | NTHR | Per-thread response available |
| rs_ready | input | NTHR | Per-thread response pop |
| rs_data | output | DATA_W*NTHR | Per-thread response head, thread t at slice t |

## Verification
A corrupted round-robin pointer appears in the very next eligible cycle as the wrong `m_thread_id`. A queue pointer that skips or repeats shows up as an out-of-order address on that thread's next grant. Miscounted response occupancy shows at once on `m_thread_busy`, one entry early or late. A misrouted response appears on the wrong thread's `rs_data` as soon as that buffer's head is read. Because the request path is combinational, a grant that ignores a busy bit is visible in the same cycle the bit is raised.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10
  } cmd_e;

  localparam logic [1:0] RSP_NONE = 2'b00;
  localparam logic [1:0] RSP_DATA = 2'b01;

  // Response buffer is "close to full" when one slot or fewer remains.
  function automatic logic close_to_full(input int unsigned used, input int unsigned depth);
    return (used + 1) >= depth;
  endfunction

  // Successor of a thread index on a ring of n threads.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/mts_fifo.sv
module mts_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_wr, do_rd;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= step(wp);
      if (do_rd) rp <= step(rp);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);             // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);            // R3
  AST_COUNT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && !rd_en) |=> $stable(count)); // R6

endmodule

// File: rtl/mts_rr.sv
module mts_rr #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          gany
);
  import mts_pkg::*;

  logic [IW-1:0] ptr;

  always_comb begin
    int cand;
    grant = '0;
    gidx  = '0;
    gany  = 1'b0;
    for (int off = 0; off < N; off++) begin
      cand = (int'(ptr) + off) % N;
      if (!gany && elig[cand]) begin
        gany        = 1'b1;
        gidx        = IW'(cand);
        grant[cand] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (gany) ptr <= IW'(ring_next(int'(gidx), N));
  end

  AST_ONE_GRANT:      assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));          // R4
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~elig) == '0);    // R9
  AST_WORK_CONSERVE:  assert property (@(posedge clk) disable iff (!rst_n) (|elig) |-> gany);         // R9

endmodule

// File: rtl/thread_req_sched.sv
module thread_req_sched #(
  parameter int NTHR      = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int REQ_DEPTH = 4,
  parameter int RSP_DEPTH = 4,
  localparam int TID_W    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTHR-1:0]          rq_valid,
  output logic [NTHR-1:0]          rq_ready,
  input  logic [NTHR-1:0]          rq_write,
  input  logic [NTHR*ADDR_W-1:0]   rq_addr,
  input  logic [NTHR*DATA_W-1:0]   rq_wdata,
  output logic [1:0]               m_cmd,
  output logic [ADDR_W-1:0]        m_addr,
  output logic [DATA_W-1:0]        m_data,
  output logic [TID_W-1:0]         m_thread_id,
  input  logic [NTHR-1:0]          s_thread_busy,
  input  logic [1:0]               s_resp,
  input  logic [DATA_W-1:0]        s_data,
  input  logic [TID_W-1:0]         s_thread_id,
  output logic [NTHR-1:0]          m_thread_busy,
  output logic [NTHR-1:0]          rs_valid,
  input  logic [NTHR-1:0]          rs_ready,
  output logic [DATA_W*NTHR-1:0]   rs_data
);
  import mts_pkg::*;

  localparam int RQW = 1 + ADDR_W + DATA_W;
  localparam int QCW = $clog2(REQ_DEPTH + 1);
  localparam int RCW = $clog2(RSP_DEPTH + 1);

  logic [NTHR-1:0]  q_empty, q_full, elig, grant;
  logic [NTHR-1:0]  rsp_push, rsp_pop, rsp_empty, rsp_full;
  logic [RQW-1:0]   q_head [NTHR];
  logic [TID_W-1:0] gidx;
  logic             gany;
  logic [RQW-1:0]   sel;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [QCW-1:0] qcnt;
    logic [RCW-1:0] rcnt;
    logic           q_push;

    assign rq_ready[t] = (qcnt != QCW'(REQ_DEPTH));
    assign q_push      = rq_valid[t] && rq_ready[t];
    assign elig[t]     = !q_empty[t] && !s_thread_busy[t];

    mts_fifo #(.W(RQW), .DEPTH(REQ_DEPTH)) u_req_q (
      .clk(clk), .rst_n(rst_n),
      .wr_en(q_push),
      .wr_data({rq_write[t], rq_addr[t*ADDR_W +: ADDR_W], rq_wdata[t*DATA_W +: DATA_W]}),
      .rd_en(grant[t]),
      .rd_data(q_head[t]),
      .full(q_full[t]), .empty(q_empty[t]), .count(qcnt)
    );

    assign rsp_push[t]      = (s_resp == RSP_DATA) && (int'(s_thread_id) == t);
    assign rsp_pop[t]       = rs_ready[t] && rs_valid[t];
    assign rs_valid[t]      = !rsp_empty[t];
    assign m_thread_busy[t] = close_to_full(int'(rcnt), RSP_DEPTH);

    mts_fifo #(.W(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rsp_push[t]),
      .wr_data(s_data),
      .rd_en(rsp_pop[t]),
      .rd_data(rs_data[t*DATA_W +: DATA_W]),
      .full(rsp_full[t]), .empty(rsp_empty[t]), .count(rcnt)
    );

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) q_full[t] |-> !rq_ready[t]);   // R6
    AST_BUSY_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                       (m_thread_busy[t] && !rsp_pop[t]) |=> m_thread_busy[t]);                          // R8
    AST_FULL_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rsp_full[t] |-> m_thread_busy[t]); // R8
  end

  mts_rr #(.N(NTHR)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .elig(elig), .grant(grant), .gidx(gidx), .gany(gany)
  );

  always_comb begin
    sel         = q_head[gidx];
    m_cmd       = CMD_IDLE;
    m_addr      = '0;
    m_data      = '0;
    m_thread_id = '0;
    if (gany) begin
      m_cmd       = sel[RQW-1] ? CMD_WRITE : CMD_READ;
      m_addr      = sel[DATA_W +: ADDR_W];
      m_data      = sel[RQW-1] ? sel[DATA_W-1:0] : '0;
      m_thread_id = gidx;
    end
  end

  AST_NO_BUSY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
                       (m_cmd != CMD_IDLE) |-> !s_thread_busy[m_thread_id]);                              // R2
  AST_CMD_LEGAL:     assert property (@(posedge clk) disable iff (!rst_n) m_cmd != 2'b11);               // R5
  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
                       (m_cmd == CMD_IDLE) |-> (m_addr == '0 && m_data == '0));                            // R9

endmodule

// File: tb/thread_req_sched_tb_top.sv
module thread_req_sched_tb_top;

  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    rq_valid = '0, rq_write = '0, s_thread_busy = '0, rs_ready = '0;
  logic [N*AW-1:0] rq_addr = '0;
  logic [N*DW-1:0] rq_wdata = '0;
  logic [1:0]      s_resp = 2'b00;
  logic [DW-1:0]   s_data = '0;
  logic [1:0]      s_thread_id = '0;
  logic [N-1:0]    rq_ready, m_thread_busy, rs_valid;
  logic [1:0]      m_cmd, m_thread_id;
  logic [AW-1:0]   m_addr;
  logic [DW-1:0]   m_data;
  logic [DW*N-1:0] rs_data;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_k [N];

  always #5 clk = ~clk;

  thread_req_sched #(.NTHR(N), .ADDR_W(AW), .DATA_W(DW), .REQ_DEPTH(4), .RSP_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata),
    .m_cmd(m_cmd), .m_addr(m_addr), .m_data(m_data), .m_thread_id(m_thread_id),
    .s_thread_busy(s_thread_busy),
    .s_resp(s_resp), .s_data(s_data), .s_thread_id(s_thread_id),
    .m_thread_busy(m_thread_busy),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data)
  );

  // Busy mask, expect-a-request flag, expected thread.
  localparam logic [6:0] ROWS [14] = '{
    {4'b0000, 1'b1, 2'd0}, {4'b0000, 1'b1, 2'd1}, {4'b0100, 1'b1, 2'd3},
    {4'b1001, 1'b1, 2'd1}, {4'b0000, 1'b1, 2'd2}, {4'b1111, 1'b0, 2'd0},
    {4'b0111, 1'b1, 2'd3}, {4'b0000, 1'b1, 2'd0}, {4'b1110, 1'b1, 2'd0},
    {4'b0000, 1'b1, 2'd1}, {4'b0000, 1'b1, 2'd2}, {4'b0000, 1'b1, 2'd3},
    {4'b0000, 1'b1, 2'd2}, {4'b0000, 1'b0, 2'd0}
  };

  function automatic logic [AW-1:0] e_addr(input int t, input int k);
    return AW'(t * 16 + k);
  endfunction
  function automatic logic [DW-1:0] e_data(input int t, input int k);
    return DW'(32'h1000 * t + 32'h10 * k + 5);
  endfunction
  function automatic logic e_wr(input int k);
    return k != 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic load(input int t, input int k);
    rq_valid[t] = 1'b1;
    rq_write[t] = e_wr(k);
    rq_addr[t*AW +: AW]  = e_addr(t, k);
    rq_wdata[t*DW +: DW] = e_data(t, k);
  endtask

  task automatic row(input logic [3:0] busy, input logic ev, input int tid, input string tag);
    int k;
    @(negedge clk);
    s_thread_busy = busy;
    #2;
    if (!ev) begin
      chk({tag, " R9 idle cmd"}, 64'(m_cmd), 64'd0);
    end else begin
      k = exp_k[tid];
      chk({tag, " R4 thread"}, 64'(m_thread_id), 64'(tid));
      chk({tag, " R3 addr"},   64'(m_addr), 64'(e_addr(tid, k)));
      chk({tag, " R5 cmd"},    64'(m_cmd), e_wr(k) ? 64'd1 : 64'd2);
      chk({tag, " R5 data"},   64'(m_data), e_wr(k) ? 64'(e_data(tid, k)) : 64'd0);
      exp_k[tid] = k + 1;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int t = 0; t < N; t++) exp_k[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R1 m_cmd idle", 64'(m_cmd), 64'd0);
    chk("R1 rq_ready", 64'(rq_ready), 64'hF);
    chk("R1 m_thread_busy", 64'(m_thread_busy), 64'd0);
    chk("R1 rs_valid", 64'(rs_valid), 64'd0);

    // Preload three requests per thread while every thread is busy.
    s_thread_busy = 4'hF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      for (int t = 0; t < N; t++) load(t, k);
    end
    @(negedge clk);
    rq_valid = '0;
    #2;
    chk("R2 all busy holds queued work", 64'(m_cmd), 64'd0);

    // Table walk over busy patterns.
    for (int i = 0; i < 14; i++)
      row(ROWS[i][6:3], ROWS[i][2], int'(ROWS[i][1:0]), "R2/R3/R4 table");

    // Queue-full boundary on thread 0.
    exp_k[0] = 0;
    s_thread_busy = 4'hF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      load(0, k);
    end
    @(negedge clk);
    rq_valid = '0;
    #2;
    chk("R6 full queue drops ready", 64'(rq_ready), 64'hE);
    @(negedge clk);
    rq_valid[0] = 1'b1;
    rq_write[0] = 1'b1;
    rq_addr[0 +: AW] = 16'h0099;
    @(negedge clk);
    rq_valid = '0;
    for (int k = 0; k < 4; k++) row(4'b0000, 1'b1, 0, "R6 drain");
    row(4'b0000, 1'b0, 0, "R6 offer while full not stored");

    // Responses: thread 2 fills to the busy threshold.
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      if (j == 2) chk("R8 two used not busy", 64'(m_thread_busy), 64'd0);
      s_resp = 2'b01; s_thread_id = 2'd2; s_data = 32'h5000 + j;
    end
    @(negedge clk);
    chk("R8 three used busy", 64'(m_thread_busy), 64'h4);
    s_resp = 2'b01; s_thread_id = 2'd1; s_data = 32'h6000;
    @(negedge clk);
    s_resp = 2'b00; s_thread_id = 2'd1; s_data = 32'h6001;
    @(negedge clk);
    s_resp = 2'b00;
    chk("R7 routed valid", 64'(rs_valid), 64'h6);
    chk("R7 thread1 head", 64'(rs_data[1*DW +: DW]), 64'h6000);
    chk("R7 thread2 head", 64'(rs_data[2*DW +: DW]), 64'h5000);
    rs_ready = 4'b0010;
    @(negedge clk);
    chk("R10 null response not stored", 64'(rs_valid[1]), 64'd0);
    rs_ready = 4'b0100;
    @(negedge clk);
    chk("R8 busy clears after pop", 64'(m_thread_busy), 64'd0);
    chk("R7 thread2 second", 64'(rs_data[2*DW +: DW]), 64'h5001);
    @(negedge clk);
    chk("R7 thread2 third", 64'(rs_data[2*DW +: DW]), 64'h5002);
    @(negedge clk);
    rs_ready = '0;
    chk("R7 thread2 drained", 64'(rs_valid), 64'd0);

    // In-flight margin: a fourth response after busy is still kept.
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      s_resp = 2'b01; s_thread_id = 2'd3; s_data = 32'h7000 + j;
    end
    @(negedge clk);
    s_resp = 2'b00;
    chk("R8 full buffer busy", 64'(m_thread_busy), 64'h8);
    for (int j = 0; j < 4; j++) begin
      chk("R7 thread3 order", 64'(rs_data[3*DW +: DW]), 64'(32'h7000 + j));
      rs_ready = 4'b1000;
      @(negedge clk);
    end
    rs_ready = '0;
    chk("R7 thread3 drained", 64'(rs_valid), 64'd0);
    chk("R8 busy released", 64'(m_thread_busy), 64'd0);

    finish_run();
  end

endmodule